// File: doc/BRIEF.md
# Checkpoint-Gated Device Store Buffer

This block sits between a processor's uncached I/O store path and a device bus. Stores aimed at devices cannot be undone once a device has seen them. The block therefore holds every such store until a checkpoint has been taken after it. From then on the store is treated as fault-free and drains to the device in the background.

When a fault is detected, every store accepted since the last checkpoint is thrown away. The block then waits while the system rolls back and the device is restored. When the restore is signalled, it sends the device again every committed store still resident, in program order, and then carries on with the committed stores not yet sent.

Each entry is stored as a SECDED codeword over address and data. A single flipped bit is corrected on the way out. A double error stops the drain and raises a fatal flag. The device side is a plain valid/ready store port, so devices need no special support.

Top module: `io_commit_buffer`

## Requirements
- R1: A store accepted on the input port is never offered on the device port until a checkpoint pulse has been taken at or after the cycle in which it was accepted.
- R2: A checkpoint pulse commits every resident uncommitted store. Committed stores are offered one per transfer in acceptance order, starting the cycle after the pulse. The store port keeps `st_ready` high while the buffer is not full.
- R3: On a fault pulse, every store accepted since the last checkpoint is dropped, including one accepted in the fault cycle itself. A dropped store is never offered to the device, even after later checkpoints, and `dev_valid` is low from the next cycle.
- R4: After a fault, a restore pulse restarts the drain at the oldest resident committed store. Stores already sent are offered again in their original order, followed by the committed stores not yet sent.
- R5: A sent store stays resident and keeps its slot until the next checkpoint frees it. With DEPTH stores resident, `st_ready` is low.
- R6: A codeword holding a single flipped bit is offered with its original address and data.
- R7: A codeword holding two flipped bits at the drain position raises `ecc_fatal` and keeps `dev_valid` low for as long as it remains there.
- R8: When a fault pulse and a checkpoint pulse arrive in the same cycle, the fault wins. The stores since the last checkpoint are dropped and nothing is committed.
- R9: Between a fault and the following restore, nothing is offered to the device, and checkpoint pulses are ignored. A store accepted in this window, or during the replay, is uncommitted and is offered only after a later checkpoint.
- R10: While `dev_valid` is high and `dev_ready` low, `dev_valid`, `dev_addr` and `dev_data` hold their values into the next cycle.
- R11: After reset the buffer is empty: `st_ready` is 1, `dev_valid` is 0 and `ecc_fatal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store offered by the processor |
| st_ready | output | 1 | Buffer can take a store (not full) |
| st_addr | input | AW | Device address of the store |
| st_data | input | DW | Store data |
| ckpt | input | 1 | Checkpoint taken (one-cycle pulse) |
| fault | input | 1 | Fault detected (one-cycle pulse) |
| restored | input | 1 | Rollback and device restore finished (one-cycle pulse) |
| dev_valid | output | 1 | Store offered to the device |
| dev_ready | input | 1 | Device accepts the offered store |
| dev_addr | output | AW | Address of the offered store, ECC-corrected |
| dev_data | output | DW | Data of the offered store, ECC-corrected |
| ecc_fatal | output | 1 | Uncorrectable error at the drain position |

## Verification
The embedded assertions check on every cycle:
- the four pointers keep their order (retire, send, commit, write) and occupancy never exceeds the depth;
- a fault retracts the write pointer to the commit boundary and silences the device port;
- a restore rewinds the send pointer to the oldest resident entry;
- a same-cycle fault leaves the commit boundary unmoved;
- a stalled offer stays stable, and a fatal ECC error never coexists with a valid offer.

Only the bench scenarios can show the actual store order seen by the device. They also show that dropped stores never reappear across later checkpoints, that replay repeats exactly the sent-but-unretired entries, and that injected single and double bit flips are corrected or flagged.

// File: rtl/io_commit_buffer.sv
module io_commit_buffer #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ckpt,
  input  logic          fault,
  input  logic          restored,
  output logic          dev_valid,
  input  logic          dev_ready,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_data,
  output logic          ecc_fatal
);

  function automatic int parity_bits(input int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  localparam int K  = AW + DW;
  localparam int R  = parity_bits(K);
  localparam int N  = K + R + 1;
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  function automatic logic [N-1:0] ecc_enc(input logic [K-1:0] d);
    logic [N-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < N; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    for (int b = 0; b < R; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < N; p++)
        if (((p >> b) & 1) == 1) x ^= c[p];
      c[1 << b] = x;
    end
    c[0] = ^c[N-1:1];
    return c;
  endfunction

  function automatic logic [K:0] ecc_dec(input logic [N-1:0] cw);
    logic [N-1:0] c;
    logic [K-1:0] d;
    logic op;
    int s;
    int j;
    c = cw;
    d = '0;
    s = 0;
    for (int b = 0; b < R; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < N; p++)
        if (((p >> b) & 1) == 1) x ^= c[p];
      if (x) s = s | (1 << b);
    end
    op = ^c;
    if (s != 0 && op && s < N) c[s] = ~c[s];
    j = 0;
    for (int p = 1; p < N; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p];
        j++;
      end
    return {(s != 0) && (!op || s >= N), d};
  endfunction

  logic [N-1:0]  mem [DEPTH];
  logic [PW-1:0] head_q, snd_q, cmt_q, tail_q;
  logic          hold_q;
  logic [PW-1:0] occ, sent_n, cmt_n;
  logic [K:0]    rd;
  logic          push, kill, take, rest, fire, pending;

  assign occ    = tail_q - head_q;
  assign sent_n = snd_q - head_q;
  assign cmt_n  = cmt_q - head_q;

  assign st_ready = (occ != FULLV);
  assign push     = st_valid && st_ready;
  assign kill     = fault && !hold_q;
  assign take     = ckpt && !hold_q && !fault;
  assign rest     = restored && hold_q;

  assign rd        = ecc_dec(mem[snd_q[IW-1:0]]);
  assign pending   = (snd_q != cmt_q);
  assign ecc_fatal = pending && rd[K];
  assign dev_valid = !hold_q && pending && !rd[K];
  assign {dev_addr, dev_data} = rd[K-1:0];
  assign fire      = dev_valid && dev_ready;

  always_ff @(posedge clk)
    if (push) mem[tail_q[IW-1:0]] <= ecc_enc({st_addr, st_data});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      snd_q  <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
      hold_q <= 1'b0;
    end else begin
      if (rest) begin
        snd_q  <= head_q;
        hold_q <= 1'b0;
      end else if (fire) begin
        snd_q <= snd_q + 1'b1;
      end
      if (kill) begin
        tail_q <= cmt_q;
        hold_q <= 1'b1;
      end else begin
        if (push) tail_q <= tail_q + 1'b1;
        if (take) begin
          head_q <= fire ? snd_q + 1'b1 : snd_q;
          cmt_q  <= push ? tail_q + 1'b1 : tail_q;
        end
      end
    end
  end

  // R5
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULLV);

  // R1
  ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent_n <= cmt_n && cmt_n <= occ);

  // R3
  drop_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (tail_q == $past(cmt_q)) && !dev_valid);

  // R8
  fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && ckpt && !hold_q) |=> cmt_q == $past(cmt_q));

  // R4
  replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest |=> (snd_q == $past(head_q)) && !hold_q);

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !dev_valid);

  // R10
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready && !fault) |=>
      dev_valid && $stable(dev_addr) && $stable(dev_data));

  // R7
  fatal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fatal |-> !dev_valid);

endmodule

// File: tb/sim_io_commit_buffer.sv
module sim_io_commit_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, ckpt = 1'b0, fault = 1'b0, restored = 1'b0, dev_ready = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, dev_valid, ecc_fatal;
  logic [AW-1:0] dev_addr;
  logic [DW-1:0] dev_data;

  int n_chk = 0;
  int n_bad = 0;
  int bt = 0;
  bit done = 1'b0;

  localparam logic [23:0] VEC [6] = '{
    24'h10_0001, 24'h22_BEEF, 24'hF0_8000,
    24'h01_7FFF, 24'hAA_5555, 24'h3C_0F0F
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  io_commit_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .ckpt(ckpt), .fault(fault),
    .restored(restored), .dev_valid(dev_valid), .dev_ready(dev_ready),
    .dev_addr(dev_addr), .dev_data(dev_data), .ecc_fatal(ecc_fatal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] v, input string req);
    chk(st_ready == 1'b1, req, {31'b0, st_ready}, 32'h1);
    st_valid = 1'b1;
    {st_addr, st_data} = v;
    bt++;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic pulse_ckpt();
    ckpt = 1'b1;
    @(negedge clk);
    ckpt = 1'b0;
  endtask

  task automatic pulse_fault();
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
  endtask

  task automatic pulse_restore();
    restored = 1'b1;
    @(negedge clk);
    restored = 1'b0;
  endtask

  task automatic expect_out(input logic [23:0] v, input string req);
    chk(dev_valid && {dev_addr, dev_data} == v, req,
        {7'b0, dev_valid, dev_addr, dev_data}, {8'h01, v});
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    chk(dev_valid == 1'b0, req, {31'b0, dev_valid}, 32'h0);
  endtask

  function automatic logic [23:0] fillv(input int i);
    return {8'(8'h80 + i), 16'(16'h1000 * i + 16'h00A5)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(st_ready == 1'b1, "R11", {31'b0, st_ready}, 32'h1);
    chk(dev_valid == 1'b0, "R11", {31'b0, dev_valid}, 32'h0);
    chk(ecc_fatal == 1'b0, "R11", {31'b0, ecc_fatal}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: hold until checkpoint, then drain in order
    foreach (VEC[i]) push(VEC[i], "R2");
    @(negedge clk);
    expect_idle("R1");
    pulse_ckpt();
    chk(dev_valid && {dev_addr, dev_data} == VEC[0], "R10",
        {8'(dev_valid), dev_addr, dev_data}, {8'h01, VEC[0]});
    @(negedge clk);
    chk(dev_valid && {dev_addr, dev_data} == VEC[0], "R10",
        {8'(dev_valid), dev_addr, dev_data}, {8'h01, VEC[0]});
    foreach (VEC[i]) expect_out(VEC[i], "R2");
    expect_idle("R1");

    // speculative stores dropped; committed ones replayed after restore
    push(24'h77_1111, "R3");
    push(24'h77_2222, "R3");
    pulse_fault();
    bt -= 2;
    expect_idle("R3");
    pulse_ckpt();
    expect_idle("R9");
    pulse_restore();
    foreach (VEC[i]) expect_out(VEC[i], "R4");
    expect_idle("R4");
    pulse_ckpt();
    @(negedge clk);
    expect_idle("R3");

    // replay with a partly sent interval; store during replay waits
    push(24'h41_000A, "R4");
    push(24'h42_000B, "R4");
    pulse_ckpt();
    expect_out(24'h41_000A, "R4");
    pulse_fault();
    expect_idle("R9");
    pulse_restore();
    push(24'h43_000C, "R9");
    expect_out(24'h41_000A, "R4");
    expect_out(24'h42_000B, "R4");
    expect_idle("R9");
    pulse_ckpt();
    expect_out(24'h43_000C, "R9");
    expect_idle("R9");

    // fault and checkpoint in the same cycle: fault wins
    push(24'h44_000D, "R8");
    ckpt = 1'b1;
    fault = 1'b1;
    @(negedge clk);
    ckpt = 1'b0;
    fault = 1'b0;
    bt -= 1;
    expect_idle("R8");
    pulse_restore();
    expect_out(24'h43_000C, "R8");
    expect_idle("R8");
    pulse_ckpt();
    @(negedge clk);
    expect_idle("R8");

    // fill to full; sent entries keep their slots until next checkpoint
    for (int i = 0; i < DEPTH; i++) push(fillv(i), "R5");
    chk(st_ready == 1'b0, "R5", {31'b0, st_ready}, 32'h0);
    pulse_ckpt();
    for (int i = 0; i < DEPTH; i++) expect_out(fillv(i), "R5");
    chk(st_ready == 1'b0, "R5", {31'b0, st_ready}, 32'h0);
    pulse_ckpt();
    chk(st_ready == 1'b1, "R5", {31'b0, st_ready}, 32'h1);

    // single-bit error corrected
    begin
      int slot;
      slot = bt % DEPTH;
      push(24'h5A_1234, "R6");
      u0.mem[slot][5] = ~u0.mem[slot][5];
      pulse_ckpt();
      expect_out(24'h5A_1234, "R6");
      expect_idle("R6");
    end

    // double-bit error blocks the drain
    begin
      int slot;
      slot = bt % DEPTH;
      push(24'hC3_9876, "R7");
      u0.mem[slot][2]  = ~u0.mem[slot][2];
      u0.mem[slot][17] = ~u0.mem[slot][17];
      pulse_ckpt();
      chk(ecc_fatal == 1'b1, "R7", {31'b0, ecc_fatal}, 32'h1);
      expect_idle("R7");
      dev_ready = 1'b1;
      repeat (3) @(negedge clk);
      dev_ready = 1'b0;
      chk(ecc_fatal == 1'b1, "R7", {31'b0, ecc_fatal}, 32'h1);
      expect_idle("R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule